// File: doc/BRIEF.md
# Predicated Vector Element Issue Loop

This block sits between instruction acceptance and an ALU back end. It turns one ordinary scalar instruction into a stream of per-element micro-ops. Each operand of the instruction (destination, first source, second source) carries a flag that marks it as a vector. Together with a vector length and a predicate bitmask, these flags decide which element operations are sent and which register numbers each one uses.

The loop issues up to `LANES` element ops per cycle. It skips elements whose predicate bit is clear and packs the enabled ones into the lowest issue slots. Each op carries its element index and register numbers that have been offset by that index. An operand advances only if it is flagged as a vector. When no operand is flagged, the instruction goes out as one plain op. In zeroing mode, a disabled element still takes a slot, but as a write-zero op instead of an ALU op. The input side uses a valid/ready handshake, and ready stays low until the last element of the current instruction has gone out.

Top module: `vec_issue_loop`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is all zero.
- R2: The first batch appears in the cycle after acceptance. Each cycle, the lowest-indexed remaining elements are issued in ascending index order, at most `LANES` of them, in lanes 0 upward with no gaps. Example: 8 elements with 6 enabled and 4 lanes give 4 ops in one cycle and 2 in the next.
- R3: The register numbers of an element op are computed per operand. A vector operand uses base + element index, modulo 2^`REG_W`. A scalar operand keeps its base number. `in_vec` bit 0 flags rd, bit 1 flags rs1 and bit 2 flags rs2.
- R4: When `in_vec` is 0, exactly one op is issued, for one cycle, in lane 0. It has index 0, the base register numbers, `out_zero`=0 and `in_opc`, whatever the vector length and predicate are.
- R5: Only elements with index below `in_vl` are issued. A length above `XLEN` acts as `XLEN`.
- R6: With `in_zero`=1, an element below the length whose predicate bit is 0 is issued with `out_zero`=1 and `out_opc`=0. An element whose predicate bit is 1 is always issued with `out_zero`=0 and `out_opc`=`in_opc`.
- R7: An instruction is taken only when `in_valid` and `in_ready` are both 1. `in_ready` is 0 in every cycle in which ops are issued. It returns to 1 in the cycle after the last batch, and an input held valid meanwhile is taken then, once.
- R8: For a vector instruction with length 0, or with no enabled element and zeroing off, nothing is issued and `in_ready` is 1 again in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Loop idle, able to take an instruction |
| in_opc | input | OPC_W | ALU operation code |
| in_rd | input | REG_W | Destination base register |
| in_rs1 | input | REG_W | First source base register |
| in_rs2 | input | REG_W | Second source base register |
| in_vec | input | 3 | Vector flags: bit0 rd, bit1 rs1, bit2 rs2 |
| in_vl | input | VL_W | Vector length |
| in_pred | input | XLEN | Predicate mask, bit i enables element i |
| in_zero | input | 1 | Zeroing mode for disabled elements |
| out_valid | output | LANES | Per-lane op valid |
| out_idx | output | LANES*IDX_W | Per-lane element index |
| out_rd | output | LANES*REG_W | Per-lane destination register |
| out_rs1 | output | LANES*REG_W | Per-lane first source register |
| out_rs2 | output | LANES*REG_W | Per-lane second source register |
| out_opc | output | LANES*OPC_W | Per-lane opcode, 0 for zeroing ops |
| out_zero | output | LANES | Per-lane write-zero flag |

## Verification
The bench uses sparse predicates that leave holes, to test lane packing and batch count. A picker that left lanes empty, or took elements out of order, would show the wrong index in a lane or need an extra cycle. It also uses a length above `XLEN`, a length cut below the mask width, and a length of zero. A design that ignored the clamp or the zero-length case would issue phantom elements or hang with ready low. A destination base near the top of the register space tests the modulo wrap, and mixed vector flags catch a scalar operand that wrongly advances. An all-scalar instruction with an empty predicate must still give one op. An instruction held valid across a busy loop must be taken exactly once when ready returns.

// File: rtl/vil_pkg.sv
package vil_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_LOOP   = 2'd2
    } vil_state_e;
endpackage

// File: rtl/vil_pick.sv
// Extracts up to LANES lowest set bits of a mask, lowest first.
module vil_pick #(
    parameter int W     = 16,
    parameter int LANES = 4,
    parameter int IDX_W = 4
) (
    input  logic [W-1:0]           mask,
    output logic [LANES-1:0]       hit,
    output logic [LANES*IDX_W-1:0] idx,
    output logic [W-1:0]           rest
);
    logic [W-1:0] chain [LANES+1];

    assign chain[0] = mask;

    for (genvar k = 0; k < LANES; k++) begin : g_slot
        logic [W-1:0]     low;
        logic [IDX_W-1:0] enc;

        assign low          = chain[k] & (~chain[k] + W'(1));
        assign hit[k]       = |low;
        assign chain[k+1]   = chain[k] & ~low;

        always_comb begin
            enc = '0;
            for (int j = 0; j < W; j++) begin
                if (low[j]) enc = IDX_W'(j);
            end
        end

        assign idx[k*IDX_W +: IDX_W] = enc;
    end

    assign rest = chain[LANES];
endmodule

// File: rtl/vil_lane.sv
// Forms one issue slot: offset registers and opcode / zero flag.
module vil_lane #(
    parameter int REG_W = 5,
    parameter int OPC_W = 4,
    parameter int IDX_W = 4
) (
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       vec,
    input  logic [REG_W-1:0] rd_b,
    input  logic [REG_W-1:0] rs1_b,
    input  logic [REG_W-1:0] rs2_b,
    input  logic             pred_bit,
    input  logic [OPC_W-1:0] opc_in,
    output logic             valid,
    output logic [IDX_W-1:0] idx_o,
    output logic [REG_W-1:0] rd,
    output logic [REG_W-1:0] rs1,
    output logic [REG_W-1:0] rs2,
    output logic [OPC_W-1:0] opc,
    output logic             zflag
);
    logic [REG_W-1:0] off;

    assign off   = REG_W'(idx);
    assign valid = hit;
    assign idx_o = hit ? idx : '0;
    assign rd    = hit ? (vec[0] ? rd_b  + off : rd_b)  : '0;
    assign rs1   = hit ? (vec[1] ? rs1_b + off : rs1_b) : '0;
    assign rs2   = hit ? (vec[2] ? rs2_b + off : rs2_b) : '0;
    assign zflag = hit && !pred_bit;
    assign opc   = (hit && pred_bit) ? opc_in : '0;
endmodule

// File: rtl/vec_issue_loop.sv
module vec_issue_loop
    import vil_pkg::*;
#(
    parameter int XLEN  = 16,
    parameter int REG_W = 5,
    parameter int OPC_W = 4,
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(XLEN),
    localparam int VL_W  = $clog2(XLEN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [OPC_W-1:0]       in_opc,
    input  logic [REG_W-1:0]       in_rd,
    input  logic [REG_W-1:0]       in_rs1,
    input  logic [REG_W-1:0]       in_rs2,
    input  logic [2:0]             in_vec,
    input  logic [VL_W-1:0]        in_vl,
    input  logic [XLEN-1:0]        in_pred,
    input  logic                   in_zero,
    output logic [LANES-1:0]       out_valid,
    output logic [LANES*IDX_W-1:0] out_idx,
    output logic [LANES*REG_W-1:0] out_rd,
    output logic [LANES*REG_W-1:0] out_rs1,
    output logic [LANES*REG_W-1:0] out_rs2,
    output logic [LANES*OPC_W-1:0] out_opc,
    output logic [LANES-1:0]       out_zero
);
    typedef struct packed {
        vil_state_e       st;
        logic [XLEN-1:0]  todo;
        logic [XLEN-1:0]  pmask;
        logic [2:0]       vec;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [OPC_W-1:0] opc;
    } ctl_t;

    ctl_t                   c_d, c_q;
    logic [XLEN-1:0]        vl_mask;
    logic [XLEN-1:0]        new_mask;
    logic [XLEN-1:0]        pick_rest;
    logic [LANES-1:0]       pick_hit;
    logic [LANES*IDX_W-1:0] pick_idx;
    logic                   accept;
    logic                   in_single;
    logic                   in_loop;

    assign in_ready  = (c_q.st == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign in_single = (c_q.st == ST_SINGLE);
    assign in_loop   = (c_q.st == ST_LOOP);

    // Length mask: bits above XLEN simply do not exist, which clamps VL.
    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            vl_mask[i] = (VL_W'(i) < in_vl);
        end
    end

    assign new_mask = vl_mask & (in_pred | {XLEN{in_zero}});

    vil_pick #(
        .W(XLEN), .LANES(LANES), .IDX_W(IDX_W)
    ) u_pick (
        .mask(c_q.todo),
        .hit (pick_hit),
        .idx (pick_idx),
        .rest(pick_rest)
    );

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.pmask = in_pred;
                    c_d.vec   = in_vec;
                    c_d.rd    = in_rd;
                    c_d.rs1   = in_rs1;
                    c_d.rs2   = in_rs2;
                    c_d.opc   = in_opc;
                    if (in_vec == 3'b000) begin
                        c_d.todo = '0;
                        c_d.st   = ST_SINGLE;
                    end else begin
                        c_d.todo = new_mask;
                        c_d.st   = (new_mask != '0) ? ST_LOOP : ST_IDLE;
                    end
                end
            end
            ST_SINGLE: c_d.st = ST_IDLE;
            ST_LOOP: begin
                c_d.todo = pick_rest;
                if (pick_rest == '0) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic             lhit;
        logic [IDX_W-1:0] lidx;
        logic             pbit;

        assign lidx = in_single ? '0 : pick_idx[k*IDX_W +: IDX_W];
        assign lhit = in_single ? (k == 0) : (in_loop && pick_hit[k]);
        assign pbit = in_single ? 1'b1 : c_q.pmask[lidx];

        vil_lane #(
            .REG_W(REG_W), .OPC_W(OPC_W), .IDX_W(IDX_W)
        ) u_lane (
            .hit     (lhit),
            .idx     (lidx),
            .vec     (c_q.vec),
            .rd_b    (c_q.rd),
            .rs1_b   (c_q.rs1),
            .rs2_b   (c_q.rs2),
            .pred_bit(pbit),
            .opc_in  (c_q.opc),
            .valid   (out_valid[k]),
            .idx_o   (out_idx[k*IDX_W +: IDX_W]),
            .rd      (out_rd[k*REG_W +: REG_W]),
            .rs1     (out_rs1[k*REG_W +: REG_W]),
            .rs2     (out_rs2[k*REG_W +: REG_W]),
            .opc     (out_opc[k*OPC_W +: OPC_W]),
            .zflag   (out_zero[k])
        );
    end
endmodule

// File: rtl/vil_issue_chk.sv
module vil_issue_chk #(
    parameter int XLEN  = 16,
    parameter int REG_W = 5,
    parameter int OPC_W = 4,
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(XLEN),
    localparam int VL_W  = $clog2(XLEN + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [2:0]             in_vec,
    input logic [VL_W-1:0]        in_vl,
    input logic [LANES-1:0]       out_valid,
    input logic [LANES*IDX_W-1:0] out_idx,
    input logic [LANES*OPC_W-1:0] out_opc,
    input logic [LANES-1:0]       out_zero
);
    // R2
    lanes_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> ((out_valid & (out_valid + LANES'(1))) == '0));

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> !in_ready);

    // R4
    scalar_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_vec == 3'b000) |=>
        (out_valid == LANES'(1)) && (out_idx[IDX_W-1:0] == '0) && (out_zero == '0));

    // R8
    empty_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_vec != 3'b000 && in_vl == '0) |=>
        (out_valid == '0) && in_ready);

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R6
        zero_no_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_zero[k] |-> (out_valid[k] && out_opc[k*OPC_W +: OPC_W] == '0));
    end
endmodule

bind vec_issue_loop vil_issue_chk #(
    .XLEN(XLEN), .REG_W(REG_W), .OPC_W(OPC_W), .LANES(LANES)
) u_chk (.*);

// File: tb/vec_issue_loop_bench.sv
module vec_issue_loop_bench;
    localparam int XLEN  = 16;
    localparam int REG_W = 5;
    localparam int OPC_W = 4;
    localparam int LANES = 4;
    localparam int IDX_W = 4;
    localparam int VL_W  = 5;
    localparam int NTV   = 10;

    typedef struct packed {
        logic [4:0]  vl;
        logic [15:0] pred;
        logic        zero;
        logic [2:0]  vec;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [3:0]  opc;
    } tv_t;

    localparam tv_t TV [NTV] = '{
        '{5'd8,  16'h00B7, 1'b0, 3'b111, 5'd4,  5'd8,  5'd12, 4'd3},
        '{5'd16, 16'hFFFF, 1'b0, 3'b101, 5'd28, 5'd7,  5'd2,  4'd5},
        '{5'd5,  16'hFFFF, 1'b0, 3'b010, 5'd1,  5'd3,  5'd9,  4'd6},
        '{5'd31, 16'h8001, 1'b0, 3'b001, 5'd0,  5'd5,  5'd6,  4'd7},
        '{5'd8,  16'h0005, 1'b1, 3'b011, 5'd10, 5'd20, 5'd30, 4'd9},
        '{5'd0,  16'hFFFF, 1'b0, 3'b111, 5'd2,  5'd3,  5'd4,  4'd1},
        '{5'd10, 16'h0000, 1'b0, 3'b100, 5'd2,  5'd3,  5'd4,  4'd2},
        '{5'd7,  16'h0000, 1'b0, 3'b000, 5'd11, 5'd12, 5'd13, 4'd4},
        '{5'd0,  16'h0000, 1'b1, 3'b110, 5'd2,  5'd3,  5'd4,  4'd8},
        '{5'd16, 16'h5A5A, 1'b1, 3'b111, 5'd16, 5'd0,  5'd31, 4'd15}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [OPC_W-1:0]       in_opc = '0;
    logic [REG_W-1:0]       in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic [2:0]             in_vec = '0;
    logic [VL_W-1:0]        in_vl = '0;
    logic [XLEN-1:0]        in_pred = '0;
    logic                   in_zero = 1'b0;
    logic [LANES-1:0]       out_valid;
    logic [LANES*IDX_W-1:0] out_idx;
    logic [LANES*REG_W-1:0] out_rd, out_rs1, out_rs2;
    logic [LANES*OPC_W-1:0] out_opc;
    logic [LANES-1:0]       out_zero;

    int checks = 0;
    int fails  = 0;
    int e_cnt;
    int e_idx [32];
    logic e_z [32];

    always #10 clk = ~clk;

    vec_issue_loop #(
        .XLEN(XLEN), .REG_W(REG_W), .OPC_W(OPC_W), .LANES(LANES)
    ) u_vec_issue_loop (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opc(in_opc), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_vec(in_vec), .in_vl(in_vl), .in_pred(in_pred), .in_zero(in_zero),
        .out_valid(out_valid), .out_idx(out_idx), .out_rd(out_rd),
        .out_rs1(out_rs1), .out_rs2(out_rs2), .out_opc(out_opc),
        .out_zero(out_zero)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int n);
        case (n)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R5";
            4: return "R6";
            5: return "R8";
            6: return "R8";
            7: return "R4";
            8: return "R8";
            default: return "R6";
        endcase
    endfunction

    // Model of the element sequence, built from the requirements.
    task automatic build_expect(input tv_t t);
        e_cnt = 0;
        if (t.vec == 3'b000) begin
            e_idx[0] = 0; e_z[0] = 1'b0; e_cnt = 1;
        end else begin
            for (int i = 0; i < XLEN; i++) begin
                if (i < int'(t.vl) && (t.pred[i] || t.zero)) begin
                    e_idx[e_cnt] = i;
                    e_z[e_cnt]   = !t.pred[i];
                    e_cnt++;
                end
            end
        end
    endtask

    function automatic logic [63:0] exp_word(input tv_t t, input int i, input logic z);
        logic [4:0] rd, rs1, rs2;
        rd  = t.vec[0] ? t.rd  + 5'(i) : t.rd;
        rs1 = t.vec[1] ? t.rs1 + 5'(i) : t.rs1;
        rs2 = t.vec[2] ? t.rs2 + 5'(i) : t.rs2;
        return {36'd0, 4'(i), rd, rs1, rs2, z, (z ? 4'd0 : t.opc)};
    endfunction

    function automatic logic [63:0] act_word(input int k);
        return {36'd0, out_idx[k*IDX_W +: IDX_W], out_rd[k*REG_W +: REG_W],
                out_rs1[k*REG_W +: REG_W], out_rs2[k*REG_W +: REG_W],
                out_zero[k], out_opc[k*OPC_W +: OPC_W]};
    endfunction

    task automatic drive(input tv_t t);
        in_vl = t.vl; in_pred = t.pred; in_zero = t.zero; in_vec = t.vec;
        in_rd = t.rd; in_rs1 = t.rs1; in_rs2 = t.rs2; in_opc = t.opc;
    endtask

    task automatic run_vec(input tv_t t, input string req);
        int n = 0;
        int cyc = 0;
        int exp_cyc;
        int nlane;
        build_expect(t);
        @(negedge clk);
        drive(t);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int guard = 0; guard < 40; guard++) begin
            if (out_valid == '0) break;
            cyc++;
            check(in_ready == 1'b0, "R7", "ready low while issuing", 64'(in_ready), 64'd0);
            nlane = (e_cnt - n > LANES) ? LANES : e_cnt - n;
            check(out_valid == LANES'((1 << nlane) - 1), req, "lanes filled",
                  64'(out_valid), 64'((1 << nlane) - 1));
            for (int k = 0; k < LANES; k++) begin
                if (out_valid[k]) begin
                    if (n < e_cnt)
                        check(act_word(k) == exp_word(t, e_idx[n], e_z[n]), req,
                              "element op", act_word(k), exp_word(t, e_idx[n], e_z[n]));
                    n++;
                end
            end
            @(negedge clk);
        end
        exp_cyc = (e_cnt + LANES - 1) / LANES;
        check(n == e_cnt, req, "op count", 64'(n), 64'(e_cnt));
        check(cyc == exp_cyc, req, "issue cycles", 64'(cyc), 64'(exp_cyc));
        check(in_ready == 1'b1, "R7", "ready back after last batch", 64'(in_ready), 64'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin : main
        tv_t a, b;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "ready in reset", 64'(in_ready), 64'd1);
        check(out_valid == '0, "R1", "valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == '0, "R1", "after reset",
              64'({in_ready, out_valid}), 64'h10);

        for (int n = 0; n < NTV; n++) run_vec(TV[n], tag_of(n));

        // R7: back-to-back, second instruction held valid during busy loop
        a = '{5'd8, 16'h00FF, 1'b0, 3'b001, 5'd3, 5'd1, 5'd2, 4'd6};
        b = '{5'd9, 16'h0000, 1'b0, 3'b000, 5'd17, 5'd18, 5'd19, 4'd11};
        @(negedge clk);
        drive(a); in_valid = 1'b1;
        @(negedge clk);
        drive(b);
        check(in_ready == 1'b0 && out_valid == 4'hF, "R7", "first batch busy",
              64'({in_ready, out_valid}), 64'h0F);
        check(out_rd[4:0] == 5'd3, "R3", "first batch lane0 rd", 64'(out_rd[4:0]), 64'd3);
        @(negedge clk);
        check(in_ready == 1'b0 && out_idx[3:0] == 4'd4, "R7", "second batch busy",
              64'({in_ready, out_idx[3:0]}), 64'h04);
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == '0, "R7", "ready returns",
              64'({in_ready, out_valid}), 64'h10);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 4'h1 && out_rd[4:0] == 5'd17 && out_opc[3:0] == 4'd11,
              "R4", "held instruction taken", 64'({out_valid, out_rd[4:0], out_opc[3:0]}),
              64'({4'h1, 5'd17, 4'd11}));
        @(negedge clk);
        check(out_valid == '0 && in_ready == 1'b1, "R7", "held instruction taken once",
              64'({in_ready, out_valid}), 64'h10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule